// File: doc/BRIEF.md
# Keyboard Port Access Trap Controller

This block sits beside the host I/O decode path and watches every cycle aimed at the legacy keyboard controller. It looks at two ports: the data port at 60h and the command/status port at 64h. For each cycle it decides whether the downstream keyboard controller sees the cycle or whether the cycle is held back and a system management interrupt is requested instead, so that firmware can emulate the controller. Each of the four access kinds (data read, data write, command read, command write) has its own trap enable and its own sticky cause latch. Firmware clears the latches with clear pulses.

A small sequencer recognises the gate-A20 handshake. This is a D1h command write, then a data write, then an optional FFh command write that closes the sequence. The steps of this handshake are always forwarded and never trapped, whatever the enables say. An access that breaks the handshake cancels it and is then judged as if the sequencer were idle. A second latch captures a USB interrupt request. It drives the PIRQD request and, when enabled, also feeds the SMI.

Top module: `kbd_port_trap`

## Requirements
- R1: While `rst_n` is low at a clock edge, the sequencer returns to idle, `seq_active`, `pass_fwd`, `cause` and `cause_usb_lat` all go to 0, and I/O strobes are ignored.
- R2: In idle, a strobed write of D1h to port 64h is forwarded (`pass_fwd` is 1 in the cycle after the strobe edge), sets no cause bit and sets `seq_active` to 1.
- R3: In idle, a strobed access to port 60h or 64h other than the R2 case is trapped when its enable bit is 1 and forwarded otherwise. The enable bits and the `cause`/`clr_cause` bits share one index: 0 = 60h read, 1 = 60h write, 2 = 64h read, 3 = 64h write. A trapped access gives `pass_fwd` = 0 and sets its cause bit at the strobe edge.
- R4: After the D1h command, a write to port 60h with any data value is forwarded even when enable bit 1 is set. It sets no cause bit and leaves `seq_active` at 1.
- R5: After that data write, a write of FFh to port 64h is forwarded without setting a cause bit, and clears `seq_active`.
- R6: While a sequence is in progress, any other access to 60h or 64h clears `seq_active` and is judged exactly as in idle (R2/R3). This includes a fresh D1h command, which restarts the sequence.
- R7: A cause bit stays set until its `clr_cause` bit is 1 at a clock edge.
- R8: When a trap and the clear for the same cause bit fall on one edge, the bit ends set.
- R9: `smi_req` is the OR of (`cause[i]` AND `trap_en[i]`) over all four bits, ORed with (`usb_lat` AND `irq_smi_en`). It is combinational from the latches and enables.
- R10: `usb_irq_req` high at an edge sets `usb_lat`, and `clr_usb` clears it; a set on the same edge wins. `pirqd_req` = `usb_lat` AND `pirqd_en`, and `cause_usb_lat` = `usb_lat` AND `irq_smi_en`.
- R11: A strobed cycle to any address other than 60h or 64h is not forwarded. It changes no cause bit and does not change `seq_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_strobe | input | 1 | One cycle per host I/O access |
| io_addr | input | 16 | I/O address of the access |
| io_write | input | 1 | 1 = write, 0 = read |
| io_wdata | input | 8 | Write data byte |
| trap_en | input | 4 | Per-access trap/SMI enable (index per R3) |
| irq_smi_en | input | 1 | Route the USB latch into the SMI |
| pirqd_en | input | 1 | Route the USB latch onto PIRQD |
| usb_irq_req | input | 1 | USB interrupt request |
| clr_cause | input | 4 | Per-bit clear of the cause latches |
| clr_usb | input | 1 | Clear of the USB latch |
| pass_fwd | output | 1 | Forward pulse for the access just seen |
| smi_req | output | 1 | System management interrupt request |
| pirqd_req | output | 1 | PIRQD interrupt request |
| cause | output | 4 | Sticky trap cause latches |
| cause_usb_lat | output | 1 | USB caused-by bit |
| seq_active | output | 1 | Gate-A20 sequence in progress |

## Verification
Two kinds of event can land on the same edge: a trap that sets a cause latch, and a software clear of that same latch. The same is true for a USB request and its clear. The random stimulus asserts clear bits independently of strobes, so these collisions occur often, and the directed part forces one explicitly. The bench model gives the set priority and judges the latch value on the following cycle. The bench also interleaves handshake steps with trapped accesses while trap enables are set. This checks that an access which breaks the sequence is trapped by the idle rules in the same cycle that the sequence is cancelled.

// File: rtl/kbt_pkg.sv
// Package: shared types and constants for the keyboard port trap block.
// Assumes the four access kinds are indexed as listed below; the enable,
// cause and clear vectors at the top-level ports all use that index.
package kbt_pkg;

    localparam int N_ACC = 4;

    // Access-kind bit positions (shared by enables, causes and clears)
    localparam int ACC_RD_DATA = 0;
    localparam int ACC_WR_DATA = 1;
    localparam int ACC_RD_CMD  = 2;
    localparam int ACC_WR_CMD  = 3;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ARMED = 2'd1,
        SEQ_DATA  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/kbt_decode.sv
// Module: kbt_decode
// Turns one strobed I/O cycle into a one-hot access-kind vector.
// Assumes io_strobe lasts one clock per access; addresses other than the
// two watched ports give an all-zero vector.
module kbt_decode #(
    parameter int ADDR_W    = 16,
    parameter int DATA_PORT = 16'h0060,
    parameter int CMD_PORT  = 16'h0064
) (
    input  logic              io_strobe,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_write,
    output logic [kbt_pkg::N_ACC-1:0] acc_vec
);
    import kbt_pkg::*;

    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_PORT);
    localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(CMD_PORT);

    logic hit_data;
    logic hit_cmd;

    // Purpose: match the address against the two watched ports
    always_comb begin
        hit_data = io_strobe && (io_addr == DATA_A);
        hit_cmd  = io_strobe && (io_addr == CMD_A);
    end

    // Purpose: split each port hit by direction into the access-kind vector
    always_comb begin
        acc_vec              = '0;
        acc_vec[ACC_RD_DATA] = hit_data && !io_write;
        acc_vec[ACC_WR_DATA] = hit_data &&  io_write;
        acc_vec[ACC_RD_CMD]  = hit_cmd  && !io_write;
        acc_vec[ACC_WR_CMD]  = hit_cmd  &&  io_write;
    end

endmodule

// File: rtl/kbt_seq_fsm.sv
// Module: kbt_seq_fsm
// Follows the gate-A20 handshake (D1h command, data write, FFh close).
// Produces a combinational bypass flag for handshake steps, so that they
// are never trapped. Any other access cancels the handshake and is treated
// as if the sequencer were idle; a fresh D1h restarts it.
// Assumes acc_vec is one-hot or zero.
module kbt_seq_fsm #(
    parameter int GATE_CMD = 8'hD1,
    parameter int CLOSE_CMD = 8'hFF
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [kbt_pkg::N_ACC-1:0] acc_vec,
    input  logic [7:0]                wdata,
    output logic                      bypass,
    output kbt_pkg::seq_state_e       state,
    output logic                      seq_active
);
    import kbt_pkg::*;

    localparam logic [7:0] GATE_B  = 8'(GATE_CMD);
    localparam logic [7:0] CLOSE_B = 8'(CLOSE_CMD);

    seq_state_e nxt;

    // Purpose: choose the next sequence state and flag handshake steps
    always_comb begin
        nxt    = state;
        bypass = 1'b0;
        if (|acc_vec) begin
            if (state == SEQ_ARMED && acc_vec[ACC_WR_DATA]) begin
                nxt    = SEQ_DATA;
                bypass = 1'b1;
            end else if (state == SEQ_DATA && acc_vec[ACC_WR_CMD] && wdata == CLOSE_B) begin
                nxt    = SEQ_IDLE;
                bypass = 1'b1;
            end else if (acc_vec[ACC_WR_CMD] && wdata == GATE_B) begin
                nxt    = SEQ_ARMED;
                bypass = 1'b1;
            end else begin
                nxt    = SEQ_IDLE;
            end
        end
    end

    // Purpose: register the state and the sequence-in-progress flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SEQ_IDLE;
            seq_active <= 1'b0;
        end else begin
            state      <= nxt;
            seq_active <= (nxt != SEQ_IDLE);
        end
    end

    // R4: the data step advances and keeps the flag high
    a_r4_data_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_ARMED && acc_vec[ACC_WR_DATA]) |=> (state == SEQ_DATA && seq_active));

    // R5: the close step drops the flag
    a_r5_close_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_DATA && acc_vec[ACC_WR_CMD] && wdata == CLOSE_B) |=> !seq_active);

    // R6: a read always cancels a sequence in progress
    a_r6_break_read: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vec[ACC_RD_DATA] || acc_vec[ACC_RD_CMD]) |=> (state == SEQ_IDLE && !seq_active));

    // R1: reset clears the sequence
    a_r1_seq_reset: assert property (@(posedge clk)
        !rst_n |=> (state == SEQ_IDLE && !seq_active));

endmodule

// File: rtl/kbt_status.sv
// Module: kbt_status
// Holds the sticky trap-cause latches and the USB interrupt latch.
// A set and a clear on the same edge leave the latch set.
// Assumes set and clear inputs are sampled once per clock.
module kbt_status #(
    parameter int N_CAUSE = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CAUSE-1:0] cause_set,
    input  logic [N_CAUSE-1:0] cause_clr,
    input  logic               usb_set,
    input  logic               usb_clr,
    output logic [N_CAUSE-1:0] cause_q,
    output logic               usb_q
);

    for (genvar i = 0; i < N_CAUSE; i++) begin : g_cause
        // Purpose: one sticky cause bit, set has priority over clear
        always_ff @(posedge clk) begin
            if (!rst_n)
                cause_q[i] <= 1'b0;
            else if (cause_set[i])
                cause_q[i] <= 1'b1;
            else if (cause_clr[i])
                cause_q[i] <= 1'b0;
        end

        // R8: a set on the same edge as a clear wins
        a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            cause_set[i] |=> cause_q[i]);

        // R7: without a clear the bit holds
        a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (cause_q[i] && !cause_clr[i]) |=> cause_q[i]);
    end

    // Purpose: USB interrupt latch, set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            usb_q <= 1'b0;
        else if (usb_set)
            usb_q <= 1'b1;
        else if (usb_clr)
            usb_q <= 1'b0;
    end

    // R10: a request always leaves the latch set
    a_r10_usb_set: assert property (@(posedge clk) disable iff (!rst_n)
        usb_set |=> usb_q);

endmodule

// File: rtl/kbd_port_trap.sv
// Module: kbd_port_trap (top)
// Decides per keyboard-port I/O cycle whether to forward it or to trap it
// and request an SMI, honouring the gate-A20 handshake bypass.
// Assumes one strobe per access; pass_fwd is a one-cycle pulse in the
// cycle after the strobe edge.
module kbd_port_trap #(
    parameter int ADDR_W    = 16,
    parameter int DATA_PORT = 16'h0060,
    parameter int CMD_PORT  = 16'h0064,
    parameter int GATE_CMD  = 8'hD1,
    parameter int CLOSE_CMD = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_strobe,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_write,
    input  logic [7:0]        io_wdata,
    input  logic [3:0]        trap_en,
    input  logic              irq_smi_en,
    input  logic              pirqd_en,
    input  logic              usb_irq_req,
    input  logic [3:0]        clr_cause,
    input  logic              clr_usb,
    output logic              pass_fwd,
    output logic              smi_req,
    output logic              pirqd_req,
    output logic [3:0]        cause,
    output logic              cause_usb_lat,
    output logic              seq_active
);
    import kbt_pkg::*;

    localparam logic [7:0] GATE_B = 8'(GATE_CMD);

    logic [N_ACC-1:0] acc_vec;
    logic [N_ACC-1:0] trap_vec;
    logic             bypass;
    logic             usb_q;
    seq_state_e       state;

    kbt_decode #(
        .ADDR_W   (ADDR_W),
        .DATA_PORT(DATA_PORT),
        .CMD_PORT (CMD_PORT)
    ) u_decode (
        .io_strobe(io_strobe),
        .io_addr  (io_addr),
        .io_write (io_write),
        .acc_vec  (acc_vec)
    );

    kbt_seq_fsm #(
        .GATE_CMD (GATE_CMD),
        .CLOSE_CMD(CLOSE_CMD)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_vec   (acc_vec),
        .wdata     (io_wdata),
        .bypass    (bypass),
        .state     (state),
        .seq_active(seq_active)
    );

    // Purpose: an access is trapped when enabled and not a handshake step
    always_comb begin
        trap_vec = acc_vec & trap_en & {N_ACC{!bypass}};
    end

    kbt_status #(
        .N_CAUSE(N_ACC)
    ) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .cause_set(trap_vec),
        .cause_clr(clr_cause),
        .usb_set  (usb_irq_req),
        .usb_clr  (clr_usb),
        .cause_q  (cause),
        .usb_q    (usb_q)
    );

    // Purpose: register the forward pulse for accesses that were not trapped
    always_ff @(posedge clk) begin
        if (!rst_n)
            pass_fwd <= 1'b0;
        else
            pass_fwd <= (|acc_vec) && !(|trap_vec);
    end

    // Purpose: combine latches and enables into the interrupt requests
    always_comb begin
        cause_usb_lat = usb_q && irq_smi_en;
        pirqd_req     = usb_q && pirqd_en;
        smi_req       = (|(cause & trap_en)) || cause_usb_lat;
    end

    // R3: a trapped access is not forwarded
    a_r3_trap_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (|trap_vec) |=> !pass_fwd);

    // R3: an untrapped access to a watched port is forwarded
    a_r3_fwd_clean: assert property (@(posedge clk) disable iff (!rst_n)
        ((|acc_vec) && !(|trap_vec)) |=> pass_fwd);

    // R2: the gate command from idle is forwarded and opens the sequence
    a_r2_gate_open: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_IDLE && acc_vec[ACC_WR_CMD] && io_wdata == GATE_B)
            |=> (pass_fwd && seq_active));

    // R11: no watched-port hit means no forward pulse
    a_r11_other_addr: assert property (@(posedge clk) disable iff (!rst_n)
        !(|acc_vec) |=> !pass_fwd);

    // R1: reset clears the visible state
    a_r1_reset: assert property (@(posedge clk)
        !rst_n |=> (!pass_fwd && cause == 4'd0 && !cause_usb_lat));

endmodule

// File: tb/test_kbd_port_trap.sv
module test_kbd_port_trap;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        io_strobe;
    logic [15:0] io_addr;
    logic        io_write;
    logic [7:0]  io_wdata;
    logic [3:0]  trap_en;
    logic        irq_smi_en;
    logic        pirqd_en;
    logic        usb_irq_req;
    logic [3:0]  clr_cause;
    logic        clr_usb;
    logic        pass_fwd;
    logic        smi_req;
    logic        pirqd_req;
    logic [3:0]  cause;
    logic        cause_usb_lat;
    logic        seq_active;

    int n_checks = 0;
    int n_errors = 0;

    // bench model state: 0 idle, 1 armed, 2 data
    int       m_state;
    logic     m_seq;
    logic     m_pass;
    logic [3:0] m_cause;
    logic     m_usb;
    string    m_tag;
    string    m_ctag;

    always #2.5 clk = ~clk;

    kbd_port_trap i_kbd_port_trap (
        .clk(clk), .rst_n(rst_n), .io_strobe(io_strobe), .io_addr(io_addr),
        .io_write(io_write), .io_wdata(io_wdata), .trap_en(trap_en),
        .irq_smi_en(irq_smi_en), .pirqd_en(pirqd_en), .usb_irq_req(usb_irq_req),
        .clr_cause(clr_cause), .clr_usb(clr_usb), .pass_fwd(pass_fwd),
        .smi_req(smi_req), .pirqd_req(pirqd_req), .cause(cause),
        .cause_usb_lat(cause_usb_lat), .seq_active(seq_active)
    );

    task automatic check(input string tag, input string what,
                         input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Model of one clock edge, using the inputs currently driven
    task automatic model_step();
        int   k;
        logic byp;
        logic trp;
        logic hit;
        logic [3:0] setv;
        setv = 4'd0;
        m_ctag = "R7";
        if (!rst_n) begin
            m_state = 0; m_seq = 0; m_pass = 0; m_cause = 0; m_usb = 0;
            m_tag = "R1"; m_ctag = "R1";
            return;
        end
        hit = io_strobe && (io_addr == 16'h0060 || io_addr == 16'h0064);
        k = (io_addr == 16'h0064 ? 2 : 0) + (io_write ? 1 : 0);
        byp = 0;
        m_tag = io_strobe ? "R11" : "R3";
        if (hit) begin
            if (m_state == 1 && k == 1) begin
                m_state = 2; byp = 1; m_tag = "R4";
            end else if (m_state == 2 && k == 3 && io_wdata == 8'hFF) begin
                m_state = 0; byp = 1; m_tag = "R5";
            end else begin
                m_tag = (m_state != 0) ? "R6" : "R3";
                if (k == 3 && io_wdata == 8'hD1) begin
                    m_state = 1; byp = 1; if (m_tag == "R3") m_tag = "R2";
                end else begin
                    m_state = 0;
                end
            end
            trp = !byp && trap_en[k];
            m_pass = !trp;
            if (trp) setv[k] = 1'b1;
        end else begin
            m_pass = 0;
        end
        m_seq = (m_state != 0);
        if (|(setv & clr_cause)) m_ctag = "R8";
        m_cause = setv | (m_cause & ~clr_cause);
        m_usb = usb_irq_req | (m_usb & ~clr_usb);
    endtask

    task automatic compare();
        logic e_smi;
        e_smi = (|(m_cause & trap_en)) | (m_usb & irq_smi_en);
        check(m_tag, "pass_fwd", {3'b0, pass_fwd}, {3'b0, m_pass});
        check(m_tag, "seq_active", {3'b0, seq_active}, {3'b0, m_seq});
        check(m_ctag, "cause", cause, m_cause);
        check("R9", "smi_req", {3'b0, smi_req}, {3'b0, e_smi});
        check("R10", "pirqd_req", {3'b0, pirqd_req}, {3'b0, m_usb & pirqd_en});
        check("R10", "cause_usb_lat", {3'b0, cause_usb_lat}, {3'b0, m_usb & irq_smi_en});
    endtask

    // Drive one cycle at the falling edge, then check at the next falling edge
    task automatic cyc(input logic st, input logic [15:0] a, input logic w,
                       input logic [7:0] d, input logic [3:0] clr,
                       input logic req, input logic cu);
        io_strobe = st; io_addr = a; io_write = w; io_wdata = d;
        clr_cause = clr; usb_irq_req = req; clr_usb = cu;
        model_step();
        @(negedge clk);
        compare();
    endtask

    function automatic logic [15:0] pick_addr(input int r);
        if (r < 45) return 16'h0060;
        if (r < 90) return 16'h0064;
        return 16'(r * 7 + 16'h0061);
    endfunction

    function automatic logic [7:0] pick_data(input int r);
        if (r < 35) return 8'hD1;
        if (r < 60) return 8'hFF;
        return 8'(r * 13);
    endfunction

    initial begin
        #(5 * 150000);
        n_errors++; n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 0; io_strobe = 0; io_addr = 0; io_write = 0; io_wdata = 0;
        trap_en = 4'hF; irq_smi_en = 0; pirqd_en = 0; usb_irq_req = 0;
        clr_cause = 0; clr_usb = 0;
        m_state = 0; m_seq = 0; m_pass = 0; m_cause = 0; m_usb = 0;
        m_tag = "R1"; m_ctag = "R1";
        @(negedge clk);
        // R1: strobes during reset have no effect
        cyc(1, 16'h0060, 0, 8'h00, 4'h0, 1, 0);
        cyc(1, 16'h0064, 1, 8'h12, 4'h0, 0, 0);
        rst_n = 1;
        irq_smi_en = 1; pirqd_en = 1;
        // R2, R4, R5: full handshake with every trap enabled
        cyc(1, 16'h0064, 1, 8'hD1, 4'h0, 0, 0);
        cyc(1, 16'h0060, 1, 8'hDF, 4'h0, 0, 0);
        cyc(1, 16'h0064, 1, 8'hFF, 4'h0, 0, 0);
        // R6: read breaks the sequence and is trapped
        cyc(1, 16'h0064, 1, 8'hD1, 4'h0, 0, 0);
        cyc(1, 16'h0064, 0, 8'h00, 4'h0, 0, 0);
        // R8: trap and clear of bit 1 on one edge
        cyc(1, 16'h0060, 1, 8'h55, 4'h2, 0, 0);
        cyc(0, 16'h0000, 0, 8'h00, 4'hF, 0, 0);
        // R11: other address ignored
        cyc(1, 16'h0061, 1, 8'hD1, 4'h0, 0, 0);
        // R10: USB request with clear on the same edge
        cyc(0, 16'h0000, 0, 8'h00, 4'h0, 1, 1);
        cyc(0, 16'h0000, 0, 8'h00, 4'h0, 0, 1);
        // R3: untrapped forward
        trap_en = 4'h0;
        cyc(1, 16'h0060, 0, 8'h00, 4'h0, 0, 0);
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 5) trap_en = 4'($urandom);
            if (r == 7) begin irq_smi_en = 1'($urandom); pirqd_en = 1'($urandom); end
            if (r == 9) rst_n = 0; else rst_n = 1;
            cyc(($urandom % 10) < 7,
                pick_addr(int'($urandom % 100)),
                1'($urandom),
                pick_data(int'($urandom % 100)),
                (($urandom % 10) == 0) ? 4'($urandom) : 4'h0,
                ($urandom % 10) == 0,
                ($urandom % 8) == 0);
        end
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule